// File: doc/BRIEF.md
# Programmable Bit-Rate Clock Generator

This block derives a square-wave bit-rate clock from a fixed system clock. Software loads a 16-bit divisor through a byte-wide write port. A select input steers each write into either the low or the high half of the divisor. A down counter walks from the divisor toward zero and reloads. Each reload flips an output flip-flop, so the output runs at clk / (2 × (divisor + 2)).

An enable input gates the whole generator. While the enable is low, the counter tracks the programmed divisor and the output rests low. The divisor should therefore be written before the enable is raised. A divisor written while the generator runs is picked up only at the next reload, so the half-period in flight always completes with the value it began with. A single-cycle tick accompanies every output edge, so downstream logic can act on the edge without detecting it itself.

Top module: `rate_clock_gen`

## Requirements
- R1: After reset, `rate_o` and `tick_o` are 0 and the stored divisor is 0.
- R2: A write with `wr_hi_i`=0 loads `wr_data_i` into divisor bits 7:0, and a write with `wr_hi_i`=1 loads bits 15:8. The other byte keeps its value.
- R3: While enabled with divisor C, `rate_o` toggles every C+2 clock edges. The first toggle falls on the (C+2)-th rising edge at which `en_i` is sampled high.
- R4: `tick_o` is high for exactly the one cycle that follows each enabled toggle of `rate_o`, and is low at all other times.
- R5: While `en_i` is low, `rate_o` and `tick_o` are held at 0 and the counter is held at the divisor. Counting resumes on the first edge at which `en_i` is high.
- R6: A divisor write while enabled does not change the half-period in progress. The new value governs every half-period that starts after the next reload.
- R7: Divisor 0 gives the fastest output: a toggle every 2 clocks, with `tick_o` never high two cycles in a row.
- R8: Divisor clk / (2 × rate) − 2 yields the requested rate. For example, 126 (0x007E) divides 9.8304 MHz down to 38400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator run enable |
| wr_i | input | 1 | Divisor byte write strobe |
| wr_hi_i | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data_i | input | 8 | Divisor byte value |
| rate_o | output | 1 | Square-wave bit-rate clock |
| tick_o | output | 1 | One-cycle pulse after each output edge |

## Verification
A byte write is visible in the divisor after one edge. A divisor that changes while the generator is disabled affects the counter only one edge later, so the bench leaves an idle cycle before raising the enable. Once enabled, `rate_o` and `tick_o` change on the edge that ends each C+2-edge half-period. The bench drives inputs on the falling edge and keeps an arithmetic model of the edge count since enable and of the divisor latched at each reload. It compares both outputs against that model on every falling edge. Mid-run divisor writes are entered into the model after that edge's reload decision, which mirrors the next-reload rule.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  parameter int unsigned BYTE_W  = 8;
  parameter int unsigned N_BYTES = 2;
  localparam int unsigned DIV_W  = BYTE_W * N_BYTES;
  localparam int unsigned CNT_W  = DIV_W + 1;
  localparam int unsigned SEL_W  = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
endpackage

// File: rtl/rcg_div_regs.sv
module rcg_div_regs
  import rcg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [DIV_W-1:0]  div_o
);
  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          byte_q <= '0;
      else if (wr_i && sel_i == SEL_W'(b))  byte_q <= data_i;
    end
    assign div_o[b*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/rcg_counter.sv
module rcg_counter
  import rcg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  // one extra count state gives div+2 edges per half-period
  assign reload = CNT_W'(div_i) + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(1);
    else if (!en_i)        cnt_q <= reload;
    else if (cnt_q == '0)  cnt_q <= reload;
    else                   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/rcg_toggle.sv
module rcg_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wrap_i,
  output logic out_o,
  output logic tick_o
);
  logic out_q, tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      out_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      out_q  <= out_q ^ wrap_i;
      tick_q <= wrap_i;
    end
  end

  assign out_o  = out_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/rate_clock_gen.sv
module rate_clock_gen
  import rcg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              rate_o,
  output logic              tick_o
);
  logic [DIV_W-1:0] div_w;
  logic [CNT_W-1:0] cnt_w;
  logic             wrap_w;
  logic [SEL_W-1:0] sel_w;

  assign sel_w = SEL_W'(wr_hi_i);

  rcg_div_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .sel_i  (sel_w),
    .data_i (wr_data_i),
    .div_o  (div_w)
  );

  rcg_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div_i  (div_w),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w)
  );

  rcg_toggle u_tgl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .wrap_i (wrap_w),
    .out_o  (rate_o),
    .tick_o (tick_o)
  );
endmodule

// File: rtl/rcg_checker.sv
module rcg_checker
  import rcg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [DIV_W-1:0] div_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             rate_i,
  input logic             tick_i
);
  assert_idle_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rate_i && !tick_i));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == CNT_W'($past(div_i)) + CNT_W'(1)));

  assert_hold_between_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i != '0) |=> $stable(rate_i) && !tick_i);

  assert_edge_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i == '0) |=> (tick_i && rate_i != $past(rate_i)));

  assert_countdown_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i != '0) |=> (cnt_i == $past(cnt_i) - CNT_W'(1)));

  assert_no_back_to_back_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);
endmodule

bind rate_clock_gen rcg_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .div_i  (div_w),
  .cnt_i  (cnt_w),
  .rate_i (rate_o),
  .tick_i (tick_o)
);

// File: tb/sim_rate_clock_gen.sv
module sim_rate_clock_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       wr_hi_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rate_o, tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // arithmetic model
  logic [15:0] tcm = '0;
  int          since = 0;
  int          cur_p = 2;
  logic        lvl = 1'b0;
  logic        etick = 1'b0;
  string       tag = "R3";

  rate_clock_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .wr_i(wr_i),
    .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i), .rate_o(rate_o), .tick_o(tick_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    etick = 1'b0;
    if (en_i) begin
      since++;
      if (since == cur_p) begin
        lvl   = ~lvl;
        etick = 1'b1;
        since = 0;
        cur_p = int'(tcm) + 2;   // reload reads divisor before this edge's write
      end
    end else begin
      lvl   = 1'b0;
      since = 0;
      cur_p = int'(tcm) + 2;
    end
    if (wr_i) begin
      if (wr_hi_i) tcm[15:8] = wr_data_i;
      else         tcm[7:0]  = wr_data_i;
    end
    chk(en_i ? {tag, " rate"} : "R5 rate idle", 32'(rate_o), 32'(lvl));
    chk(en_i ? "R4 tick" : "R5 tick idle", 32'(tick_o), 32'(etick));
  endtask

  task automatic wbyte(input logic hi, input logic [7:0] v);
    wr_i = 1'b1; wr_hi_i = hi; wr_data_i = v;
    step();
    wr_i = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic program_div(input logic [15:0] c);
    en_i = 1'b0;
    wbyte(1'b0, c[7:0]);
    wbyte(1'b1, c[15:8]);
    step();
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    chk("R1 rate", 32'(rate_o), 32'd0);
    chk("R1 tick", 32'(tick_o), 32'd0);
    run(4);

    // R5: disabled with a programmed divisor stays quiet
    program_div(16'd3);
    run(20);

    // R3 / R7: sweep small divisors
    for (int c = 0; c < 16; c++) begin
      tag = (c == 0) ? "R7" : "R3";
      program_div(16'(c));
      en_i = 1'b1;
      run(6 * (c + 2) + 1);
      en_i = 1'b0;
      step();
    end

    // R2: byte-wise loading
    tag = "R2";
    program_div(16'h0105);
    en_i = 1'b1;
    run(3 * 263 + 2);
    en_i = 1'b0;
    step();
    wbyte(1'b0, 8'h03);  // high byte stays 0x01
    step();
    en_i = 1'b1;
    run(2 * 261 + 2);
    en_i = 1'b0;
    step();

    // R6: change while enabled applies from next reload
    tag = "R6";
    program_div(16'd10);
    en_i = 1'b1;
    run(3 * 12 + 2);
    wbyte(1'b1, 8'h00);
    wbyte(1'b0, 8'h04);
    run(100);
    en_i = 1'b0;
    step();

    // R8: divisor for 38400 from a 9.8304 MHz clock
    tag = "R8";
    k = 9830400 / (2 * 38400) - 2;
    chk("R8 divisor", 32'(k), 32'h7E);
    program_div(16'(k));
    en_i = 1'b1;
    run(4 * 128 + 3);
    en_i = 1'b0;
    step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule